// File: doc/BRIEF.md
# Calendar Clock Register Block

This block keeps a running calendar: seconds, minutes and hours, plus day of month, month and a year offset. A one-cycle `tick` input marks the passing of each second. Software reaches the counters through a small memory-mapped bus with three word offsets: a control/status word at 0x0, the date word at 0x4 and the time word at 0x8. Writes go through the same bus, and reads are combinational.

Software writes to the time or date word do not land in the counters at once. Each write is held in a staging register for a fixed number of clock cycles, set by a parameter, before it is committed. While that commit is pending, a busy flag for that word is visible in the control word. Software is expected to write the time, wait for its busy flag to drop, then write the date and wait again. Writes of zero to both words, made before the real values, are legal. Reads always return the live counters. A tick can fall between two reads, so software re-reads until two successive reads agree.

The year is stored as an offset from a base year. Its width is a parameter with two variants. With 6 bits the leap flag sits at bit 22 (base year 2010). With 8 bits it sits at bit 24 (base year 1970). The leap flag is written by software. The block uses it to pick the length of February and clears it when the year advances.

Top module: `cal_clock_regs`

## Requirements
- R1: After reset the time word reads 0, the date word reads day 1 and month 1 with year offset 0 and the leap flag clear, and the control word reads 0.
- R2: The time word holds seconds in bits [5:0], minutes in [13:8] and hours in [20:16]. The date word holds the day in [4:0], the month in [11:8] (1 = January), the year offset starting at bit 16 and the leap flag just above the year field. All other bits read as 0.
- R3: A write to offset 0x8 sets control bit 8 on the next cycle. The bit stays set for exactly COMMIT_CYCLES cycles. The written value appears in the time word in the same cycle that bit 8 clears.
- R4: A write to offset 0x4 sets control bit 7 and commits the date value with the same timing as R3.
- R5: A write to a word whose busy flag is set is ignored, including a write in the final busy cycle. Writes to offset 0x0 or to unmapped offsets change nothing.
- R6: On each tick, seconds count up. Seconds and minutes roll from 59 (or any larger stored value) to 0 and carry into the next field. Hours roll from 23 (or above) to 0 and carry into the date.
- R7: On a date carry, the day advances, or returns to 1 once it has reached the month length. The month lengths are 31 days for months 1, 3, 5, 7, 8, 10 and 12 and for any value outside 1 to 12, and 30 days for months 4, 6, 9 and 11. February has 29 days when the leap flag is set and 28 otherwise.
- R8: When the day rolls over in month 12 (or above), the month becomes 1, the year offset increments and the leap flag clears.
- R9: Ticks keep advancing the live counters while a commit is pending. In the commit cycle the committed value wins over the tick. A time commit in that cycle also suppresses the date carry, and a date commit wins over a date carry.
- R10: YEAR_W picks the year variant: 6 or 8 bits, with the leap flag at bit 16+YEAR_W. The year offset wraps from its maximum value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance enable, one cycle wide |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
A wrong carry or month-length decision shows up at the date word in the same cycle as the tick that rolls past midnight, so a comparison on every clock catches it at once. A commit counter that is off by one moves the falling edge of the busy bit and the moment the staged value appears, both by exactly one cycle. A staged value that a write overwrote during its busy window surfaces only when the commit lands, COMMIT_CYCLES cycles later. The two year variants are run side by side from the same bus traffic, so a misplaced leap bit or year mask diverges at the first date read.

// File: rtl/cal_pkg.sv
package cal_pkg;

   localparam int OFS_CTRL = 'h0;
   localparam int OFS_DATE = 'h4;
   localparam int OFS_TIME = 'h8;

   localparam int CTRL_TIME_BUSY = 8;
   localparam int CTRL_DATE_BUSY = 7;

   typedef struct packed {
      logic [4:0] hr;
      logic [5:0] mn;
      logic [5:0] sc;
   } hms_t;

   localparam int HMS_W = $bits(hms_t);

   function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
      logic [4:0] d;
      case (mon)
         4'd2:                      d = leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:   d = 5'd30;
         default:                   d = 5'd31;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/cal_commit.sv
module cal_commit #(
   parameter int DW            = 17,
   parameter int COMMIT_CYCLES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic          busy,
   output logic          load,
   output logic [DW-1:0] load_val
);

   localparam int CNT_W = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_START = CNT_W'(COMMIT_CYCLES - 1);

   generate
      if (COMMIT_CYCLES < 1) begin : g_bad_delay
         $error("cal_commit: COMMIT_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         load_val <= '0;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end else if (wr) begin
         busy     <= 1'b1;
         cnt      <= CNT_START;
         load_val <= wdata;
      end
   end

   assign load = busy && (cnt == '0);

   // R3 and R4: busy holds until the countdown is spent
   assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |=> busy);

   // R5: staged value untouched by writes while busy
   assert_ignore_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr) |=> $stable(load_val));

endmodule

// File: rtl/cal_time.sv
module cal_time
   import cal_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load,
   input  hms_t load_val,
   output hms_t now,
   output logic day_roll
);

   logic sc_top, mn_top, hr_top;

   assign sc_top   = now.sc >= 6'd59;
   assign mn_top   = now.mn >= 6'd59;
   assign hr_top   = now.hr >= 5'd23;
   assign day_roll = tick && !load && sc_top && mn_top && hr_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now <= '0;
      end else if (load) begin
         now <= load_val;
      end else if (tick) begin
         if (!sc_top) begin
            now.sc <= now.sc + 6'd1;
         end else begin
            now.sc <= '0;
            if (!mn_top) begin
               now.mn <= now.mn + 6'd1;
            end else begin
               now.mn <= '0;
               now.hr <= hr_top ? 5'd0 : now.hr + 5'd1;
            end
         end
      end
   end

   assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && now.sc == 6'd59) |=> (now.sc == 6'd0));

endmodule

// File: rtl/cal_date.sv
module cal_date
   import cal_pkg::*;
#(
   parameter int YEAR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              load,
   input  logic [4:0]        ld_day,
   input  logic [3:0]        ld_mon,
   input  logic [YEAR_W-1:0] ld_year,
   input  logic              ld_leap,
   output logic [4:0]        day,
   output logic [3:0]        mon,
   output logic [YEAR_W-1:0] year,
   output logic              leap
);

   logic [4:0] dim;
   logic       month_end, year_end;

   assign dim       = month_days(mon, leap);
   assign month_end = day >= dim;
   assign year_end  = mon >= 4'd12;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         day  <= 5'd1;
         mon  <= 4'd1;
         year <= '0;
         leap <= 1'b0;
      end else if (load) begin
         day  <= ld_day;
         mon  <= ld_mon;
         year <= ld_year;
         leap <= ld_leap;
      end else if (adv) begin
         if (!month_end) begin
            day <= day + 5'd1;
         end else begin
            day <= 5'd1;
            if (!year_end) begin
               mon <= mon + 4'd1;
            end else begin
               mon  <= 4'd1;
               year <= year + 1'b1;
               leap <= 1'b0;
            end
         end
      end
   end

   assert_day_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && day < dim) |=> (day == $past(day) + 5'd1));

   assert_new_year_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && month_end && year_end) |=> (mon == 4'd1 && !leap && day == 5'd1));

endmodule

// File: rtl/cal_clock_regs.sv
module cal_clock_regs
   import cal_pkg::*;
#(
   parameter int YEAR_W        = 6,
   parameter int COMMIT_CYCLES = 4,
   parameter int ADDR_W        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);

   localparam int LEAP_POS = 16 + YEAR_W;
   localparam int DATE_W   = 5 + 4 + YEAR_W + 1;

   generate
      if (YEAR_W != 6 && YEAR_W != 8) begin : g_bad_year
         $error("cal_clock_regs: YEAR_W must be 6 or 8");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("cal_clock_regs: ADDR_W must be at least 4");
      end
   endgenerate

   logic wr_time, wr_date;
   assign wr_time = bus_wr && (bus_addr == ADDR_W'(OFS_TIME));
   assign wr_date = bus_wr && (bus_addr == ADDR_W'(OFS_DATE));

   hms_t              time_in, time_stage, time_now;
   logic [DATE_W-1:0] date_in, date_stage;
   logic              time_busy, time_load, date_busy, date_load, day_roll;
   logic [4:0]        day;
   logic [3:0]        mon;
   logic [YEAR_W-1:0] year;
   logic              leap;
   logic              unused_wbits;

   assign time_in      = '{hr: bus_wdata[20:16], mn: bus_wdata[13:8], sc: bus_wdata[5:0]};
   assign date_in      = {bus_wdata[LEAP_POS], bus_wdata[16 +: YEAR_W], bus_wdata[11:8], bus_wdata[4:0]};
   assign unused_wbits = ^bus_wdata;

   cal_commit #(.DW(HMS_W), .COMMIT_CYCLES(COMMIT_CYCLES)) u_time_commit (
      .clk(clk), .rst_n(rst_n), .wr(wr_time), .wdata(time_in),
      .busy(time_busy), .load(time_load), .load_val(time_stage)
   );

   cal_commit #(.DW(DATE_W), .COMMIT_CYCLES(COMMIT_CYCLES)) u_date_commit (
      .clk(clk), .rst_n(rst_n), .wr(wr_date), .wdata(date_in),
      .busy(date_busy), .load(date_load), .load_val(date_stage)
   );

   cal_time u_time (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(time_load),
      .load_val(time_stage), .now(time_now), .day_roll(day_roll)
   );

   cal_date #(.YEAR_W(YEAR_W)) u_date (
      .clk(clk), .rst_n(rst_n), .adv(day_roll), .load(date_load),
      .ld_day(date_stage[4:0]), .ld_mon(date_stage[8:5]),
      .ld_year(date_stage[9 +: YEAR_W]), .ld_leap(date_stage[DATE_W-1]),
      .day(day), .mon(mon), .year(year), .leap(leap)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CTRL)) begin
         bus_rdata[CTRL_TIME_BUSY] = time_busy;
         bus_rdata[CTRL_DATE_BUSY] = date_busy;
      end else if (bus_addr == ADDR_W'(OFS_DATE)) begin
         bus_rdata[4:0]             = day;
         bus_rdata[11:8]            = mon;
         bus_rdata[16 +: YEAR_W]    = year;
         bus_rdata[LEAP_POS]        = leap;
      end else if (bus_addr == ADDR_W'(OFS_TIME)) begin
         bus_rdata[5:0]   = time_now.sc;
         bus_rdata[13:8]  = time_now.mn;
         bus_rdata[20:16] = time_now.hr;
      end
   end

   // R9: a date commit always wins over a carry in the same cycle
   assert_date_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      date_load |=> (day == $past(date_stage[4:0]) && mon == $past(date_stage[8:5])));

endmodule

// File: tb/tb_cal_clock_regs.sv
`timescale 1ns/100ps
module tb_cal_clock_regs;

   localparam int C = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        wr_i = 1'b0;
   logic [3:0]  addr_i = 4'h0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rd6, rd8;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   cal_clock_regs #(.YEAR_W(6), .COMMIT_CYCLES(C), .ADDR_W(4)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick_i), .bus_wr(wr_i),
      .bus_addr(addr_i), .bus_wdata(wdata_i), .bus_rdata(rd6)
   );

   cal_clock_regs #(.YEAR_W(8), .COMMIT_CYCLES(C), .ADDR_W(4)) dut_w8 (
      .clk(clk), .rst_n(rst_n), .tick(tick_i), .bus_wr(wr_i),
      .bus_addr(addr_i), .bus_wdata(wdata_i), .bus_rdata(rd8)
   );

   // behavioural reference, index 0 = 6-bit year, 1 = 8-bit year
   int sc[2], mn[2], hr[2], dy[2], mo[2], yr[2], lp[2];
   int tb[2], tc[2], db[2], dc[2];
   logic [31:0] tp[2], dp[2];

   function automatic int yw(int v);
      return (v == 0) ? 6 : 8;
   endfunction

   function automatic int mdays(int m, int l);
      if (m == 2) return (l != 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   function automatic logic [31:0] expect_rd(int v, logic [3:0] a);
      logic [31:0] r = '0;
      if (a == 4'h0) r = (32'(tb[v]) << 8) | (32'(db[v]) << 7);
      else if (a == 4'h4) r = 32'(dy[v]) | (32'(mo[v]) << 8) | (32'(yr[v]) << 16) | (32'(lp[v]) << (16 + yw(v)));
      else if (a == 4'h8) r = 32'(sc[v]) | (32'(mn[v]) << 8) | (32'(hr[v]) << 16);
      return r;
   endfunction

   always @(posedge clk) begin
      for (int v = 0; v < 2; v++) begin
         bit ct, cd, roll;
         if (!rst_n) begin
            sc[v] = 0; mn[v] = 0; hr[v] = 0; dy[v] = 1; mo[v] = 1; yr[v] = 0; lp[v] = 0;
            tb[v] = 0; tc[v] = 0; db[v] = 0; dc[v] = 0; tp[v] = 0; dp[v] = 0;
         end else begin
            ct = (tb[v] != 0) && (tc[v] == 0);
            cd = (db[v] != 0) && (dc[v] == 0);
            roll = 0;
            if (ct) begin
               sc[v] = int'(tp[v][5:0]); mn[v] = int'(tp[v][13:8]); hr[v] = int'(tp[v][20:16]);
            end else if (tick_i) begin
               if (sc[v] >= 59) begin
                  sc[v] = 0;
                  if (mn[v] >= 59) begin
                     mn[v] = 0;
                     if (hr[v] >= 23) begin hr[v] = 0; roll = 1; end
                     else hr[v] = hr[v] + 1;
                  end else mn[v] = mn[v] + 1;
               end else sc[v] = sc[v] + 1;
            end
            if (cd) begin
               dy[v] = int'(dp[v][4:0]); mo[v] = int'(dp[v][11:8]);
               yr[v] = int'(dp[v] >> 16) % (1 << yw(v));
               lp[v] = int'(dp[v][16 + yw(v)]);
            end else if (roll) begin
               if (dy[v] >= mdays(mo[v], lp[v])) begin
                  dy[v] = 1;
                  if (mo[v] >= 12) begin
                     mo[v] = 1; yr[v] = (yr[v] + 1) % (1 << yw(v)); lp[v] = 0;
                  end else mo[v] = mo[v] + 1;
               end else dy[v] = dy[v] + 1;
            end
            if (tb[v] != 0) begin
               if (tc[v] == 0) tb[v] = 0; else tc[v] = tc[v] - 1;
            end else if (wr_i && addr_i == 4'h8) begin
               tb[v] = 1; tc[v] = C - 1; tp[v] = wdata_i;
            end
            if (db[v] != 0) begin
               if (dc[v] == 0) db[v] = 0; else dc[v] = dc[v] - 1;
            end else if (wr_i && addr_i == 4'h4) begin
               db[v] = 1; dc[v] = C - 1; dp[v] = wdata_i;
            end
         end
      end
   end

   always @(posedge clk) begin
      #1;
      if (!done) begin
         for (int v = 0; v < 2; v++) begin
            logic [31:0] got, exp_v;
            got = (v == 0) ? rd6 : rd8;
            exp_v = expect_rd(v, addr_i);
            n_run++;
            if (got !== exp_v) begin
               n_fail++;
               $display("FAIL %s yw=%0d addr=%h actual=%h expected=%h at %0t",
                        cur_req, yw(v), addr_i, got, exp_v, $time);
            end
         end
      end
   end

   int rot = 0;

   task automatic step(input logic t, input logic w, input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      tick_i = t; wr_i = w; addr_i = a; wdata_i = d;
   endtask

   task automatic run(input int n, input logic t);
      for (int i = 0; i < n; i++) begin
         step(t, 1'b0, 4'(rot * 4), 32'h0);
         rot = (rot + 1) % 3;
      end
   endtask

   function automatic logic [31:0] tm(int h, int m, int s);
      return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
   endfunction

   function automatic logic [31:0] dt(int d, int m, int y, logic [31:0] extra);
      return 32'(d) | (32'(m) << 8) | (32'(y) << 16) | extra;
   endfunction

   task automatic set_time(int h, int m, int s);
      step(1'b0, 1'b1, 4'h8, tm(h, m, s));
      run(C + 2, 1'b0);
   endtask

   task automatic set_date(logic [31:0] d);
      step(1'b0, 1'b1, 4'h4, d);
      run(C + 2, 1'b0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run(6, 1'b0);

      // zero writes, then time and date commit timing
      cur_req = "R3"; set_time(0, 0, 0);
      cur_req = "R4"; set_date(32'h0);

      // writes while busy and to control/unmapped offsets
      cur_req = "R5";
      step(1'b0, 1'b1, 4'h8, tm(23, 59, 50));
      step(1'b0, 1'b1, 4'h8, tm(1, 2, 3));
      step(1'b0, 1'b1, 4'h0, 32'hFFFF_FFFF);
      step(1'b0, 1'b1, 4'hC, 32'hFFFF_FFFF);
      run(C + 2, 1'b0);

      // layout and variant: bit 22 is leap (6-bit) or year bit (8-bit)
      cur_req = "R2";
      set_date(dt(28, 2, 5, (32'h1 << 22) | (32'h1 << 24)));

      cur_req = "R6"; run(12, 1'b1);
      cur_req = "R7";
      set_time(23, 59, 58); run(4, 1'b1);
      set_date(dt(28, 2, 7, 32'h0)); set_time(23, 59, 58); run(4, 1'b1);
      set_date(dt(30, 4, 7, 32'h0)); set_time(23, 59, 59); run(3, 1'b1);
      set_date(dt(31, 0, 7, 32'h0)); set_time(23, 59, 59); run(3, 1'b1);

      cur_req = "R8";
      set_date(dt(31, 12, 3, (32'h1 << 22) | (32'h1 << 24)));
      set_time(23, 59, 59); run(3, 1'b1);

      cur_req = "R10";
      set_date(dt(31, 12, 255, 32'h1 << 24));
      set_time(23, 59, 59); run(3, 1'b1);

      cur_req = "R6";
      set_time(10, 59, 58); run(4, 1'b1);
      set_time(5, 63, 63); run(3, 1'b1);

      cur_req = "R9";
      set_time(23, 59, 50);
      step(1'b1, 1'b1, 4'h8, tm(23, 59, 59));
      run(C + 8, 1'b1);
      set_time(23, 59, 55);
      step(1'b1, 1'b1, 4'h4, dt(15, 6, 9, 32'h0));
      run(C + 8, 1'b1);

      run(3, 1'b0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule